// File: doc/BRIEF.md
# Coded Ratio Pulse Divider

This block reduces the frequency of a speed pulse train by an integer ratio picked with a 3-bit code. It drives two outputs. The primary output runs at the input frequency divided by the selected ratio. The secondary output runs at half the primary frequency. Both outputs are registered and have a duty cycle as close to one half as an integer ratio allows. One code value switches both outputs off.

The pulse input must already be synchronous to `clk`, and each of its levels must last at least two clock cycles. The block counts rising edges of the input and flips the primary output at half-period boundaries. The secondary output flips on every rising edge of the primary output.

When the ratio code changes, both outputs are cleared on the next clock edge and the count starts again. This means no shortened pulse left over from the old ratio ever appears. In pass-through mode, the primary output also stays low after a code change or reset until the input shows a fresh rising edge. This way a partly elapsed input pulse is never forwarded.

Top module: `ratio_pulse_divider`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, both `full_out` and `half_out` are 0.
- R2: With code 3'b000 (pass-through), `full_out` follows the level of `pulse_in`, and `half_out` toggles on each rising edge of `full_out`.
- R3: The ratio N for each code is: 3'b001 gives 9, 3'b010 gives 7, 3'b011 gives 11, 3'b100 gives 6, 3'b101 gives 10, 3'b110 gives 8, and 3'b000 gives 1. In every divide mode, `full_out` completes one period per N input rising edges.
- R4: After a restart, `full_out` stays low for (N+1)/2 input rising edges (integer division) and then stays high for N/2 rising edges. For even N the two phases are equal. For odd N the low phase is one edge longer.
- R5: `half_out` toggles exactly when `full_out` rises, so it runs at half the rate of `full_out`. It never rises in a cycle in which `full_out` does not rise.
- R6: With code 3'b111, both outputs are held at 0 and input edges have no effect.
- R7: On the clock edge that first samples a new code value, both outputs go to 0 and the edge count restarts from zero under the new code.
- R8: In pass-through mode after a code change or reset, `full_out` stays at 0 while `pulse_in` remains high. It follows the input only from the next input rising edge onward.
- R9: A level change of `pulse_in` sampled on one clock edge reaches `full_out` on the following clock edge. The result is visible two edges after the input was driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Synchronized speed pulse level |
| div_code | input | 3 | Ratio select code |
| full_out | output | 1 | Divided output, full-rate class |
| half_out | output | 1 | Divided output, half-rate class |

## Verification
An input level sampled at one rising edge is registered in the edge stage. The edge detected from it updates both outputs at the next rising edge. The checks therefore look at the outputs on the second falling edge after the stimulus is driven, or later once the level has settled. A code change takes effect on the first rising edge that samples it, so its check is made on the falling edge right after that. The bench keeps an independent count of input rising edges since the last restart. From that count and the ratio table it computes the expected levels of both outputs.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

  localparam int CODE_W = 3;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_PASS = 3'b000;
  localparam code_t CODE_OFF  = 3'b111;

  // Ratio selected by each code; the off code yields 0.
  function automatic int unsigned ratio_of(input code_t c);
    case (c)
      3'b000:  ratio_of = 1;
      3'b001:  ratio_of = 9;
      3'b010:  ratio_of = 7;
      3'b011:  ratio_of = 11;
      3'b100:  ratio_of = 6;
      3'b101:  ratio_of = 10;
      3'b110:  ratio_of = 8;
      default: ratio_of = 0;
    endcase
  endfunction

endpackage

// File: rtl/rpd_in_edge.sv
module rpd_in_edge #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= pulse_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pulse_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/rpd_code_track.sv
module rpd_code_track
  import rpd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  code_t            div_code,
  input  logic             rise,
  output logic             code_chg,
  output logic             hold,
  output logic             bypass,
  output logic             off,
  output logic [CNT_W-1:0] lo_len,
  output logic [CNT_W-1:0] hi_len
);

  code_t       code_q;
  logic        hold_q;
  int unsigned ratio;

  // The code register loads even in reset, so it always trails the pin by one edge.
  always_ff @(posedge clk) begin
    code_q <= div_code;
  end

  always_ff @(posedge clk) begin
    if (rst)           hold_q <= 1'b1;
    else if (code_chg) hold_q <= 1'b1;
    else if (rise)     hold_q <= 1'b0;
  end

  assign code_chg = (div_code != code_q);
  assign hold     = hold_q;

  always_comb begin
    ratio  = ratio_of(code_q);
    bypass = (code_q == CODE_PASS);
    off    = (code_q == CODE_OFF);
    lo_len = CNT_W'((ratio + 1) / 2);
    hi_len = CNT_W'(ratio / 2);
  end

endmodule

// File: rtl/rpd_phase_counter.sv
module rpd_phase_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             level,
  input  logic             code_chg,
  input  logic             hold,
  input  logic             bypass,
  input  logic             off,
  input  logic [CNT_W-1:0] lo_len,
  input  logic [CNT_W-1:0] hi_len,
  output logic             full_q,
  output logic             half_q
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] target;
  logic             full_n, half_n, clear;

  always_comb begin
    clear   = code_chg | off;
    target  = full_q ? hi_len : lo_len;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    cnt_n   = cnt_q;
    full_n  = full_q;
    half_n  = half_q;
    if (clear) begin
      cnt_n  = '0;
      full_n = 1'b0;
      half_n = 1'b0;
    end else if (bypass) begin
      cnt_n  = '0;
      full_n = level & ~(hold & ~rise);
    end else if (rise) begin
      if (cnt_inc >= {1'b0, target}) begin
        cnt_n  = '0;
        full_n = ~full_q;
      end else begin
        cnt_n  = cnt_inc[CNT_W-1:0];
      end
    end
    if (!clear && !full_q && full_n) half_n = ~half_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      full_q <= full_n;
      half_q <= half_n;
    end
  end

endmodule

// File: rtl/ratio_pulse_divider.sv
module ratio_pulse_divider #(
  parameter int IN_STAGES = 1,
  parameter int CNT_W     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pulse_in,
  input  logic [2:0] div_code,
  output logic       full_out,
  output logic       half_out
);

  logic             level, rise;
  logic             code_chg, hold, bypass, off;
  logic [CNT_W-1:0] lo_len, hi_len;

  rpd_in_edge #(.STAGES(IN_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pulse_in (pulse_in),
    .level    (level),
    .rise     (rise)
  );

  rpd_code_track #(.CNT_W(CNT_W)) u_code (
    .clk      (clk),
    .rst      (rst),
    .div_code (div_code),
    .rise     (rise),
    .code_chg (code_chg),
    .hold     (hold),
    .bypass   (bypass),
    .off      (off),
    .lo_len   (lo_len),
    .hi_len   (hi_len)
  );

  rpd_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .level    (level),
    .code_chg (code_chg),
    .hold     (hold),
    .bypass   (bypass),
    .off      (off),
    .lo_len   (lo_len),
    .hi_len   (hi_len),
    .full_q   (full_out),
    .half_q   (half_out)
  );

endmodule

// File: rtl/rpd_checker.sv
module rpd_checker (
  input logic       clk,
  input logic       rst,
  input logic       pulse_in,
  input logic [2:0] div_code,
  input logic       full_out,
  input logic       half_out
);

  a_r1_low_after_reset: assert property (@(posedge clk)
    rst |=> (!full_out && !half_out));

  a_r5_half_on_full_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(half_out) |-> $rose(full_out));

  a_r6_off_code_silent: assert property (@(posedge clk) disable iff (rst)
    (div_code == 3'b111 && $past(div_code) == 3'b111) |=> (!full_out && !half_out));

  a_r7_change_clears: assert property (@(posedge clk) disable iff (rst)
    (div_code != $past(div_code)) |=> (!full_out && !half_out));

  a_r2_pass_low_input: assert property (@(posedge clk) disable iff (rst)
    (div_code == 3'b000 && $past(div_code) == 3'b000 && !pulse_in && !$past(pulse_in))
      |=> !full_out);

endmodule

bind ratio_pulse_divider rpd_checker u_rpd_checker (
  .clk      (clk),
  .rst      (rst),
  .pulse_in (pulse_in),
  .div_code (div_code),
  .full_out (full_out),
  .half_out (half_out)
);

// File: tb/tb_ratio_pulse_divider.sv
module tb_ratio_pulse_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pulse_in = 1'b0;
  logic [2:0] div_code = 3'b111;
  logic       full_out, half_out;

  int tests = 0;
  int fails = 0;
  int rcnt  = 0;   // input rising edges since last restart
  int nrat  = 0;   // current ratio, 0 = off
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ratio_pulse_divider dut (
    .clk      (clk),
    .rst      (rst),
    .pulse_in (pulse_in),
    .div_code (div_code),
    .full_out (full_out),
    .half_out (half_out)
  );

  function automatic int ratio(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 9;
      3'b010: return 7;
      3'b011: return 11;
      3'b100: return 6;
      3'b101: return 10;
      3'b110: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_full(input int r, input int n);
    if (n == 0 || r == 0) return 1'b0;
    if (n == 1) return 1'b1;
    return ((r % n) >= (n + 1) / 2);
  endfunction

  function automatic logic exp_half(input int r, input int n);
    int lo;
    if (n == 0) return 1'b0;
    lo = (n + 1) / 2;
    if (r < lo) return 1'b0;
    return logic'((((r - lo) / n) + 1) % 2);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Change the code and check the outputs clear on the sampling edge (R7).
  task automatic set_code(input logic [2:0] c);
    @(negedge clk);
    div_code = c;
    @(negedge clk);
    chk("R7 full cleared on code change", full_out, 1'b0);
    chk("R7 half cleared on code change", half_out, 1'b0);
    rcnt = 0;
    nrat = ratio(c);
  endtask

  // One input pulse: 3 cycles high, 3 cycles low, checked in both levels.
  task automatic one_pulse(input string tag);
    @(negedge clk);
    pulse_in = 1'b1;
    rcnt++;
    repeat (3) @(negedge clk);
    chk({tag, " full high level"}, full_out, exp_full(rcnt, nrat));
    chk({tag, " half high level"}, half_out, exp_half(rcnt, nrat));
    pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " full low level"}, full_out, (nrat == 1) ? 1'b0 : exp_full(rcnt, nrat));
    chk({tag, " half low level"}, half_out, exp_half(rcnt, nrat));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 full in reset", full_out, 1'b0);
    chk("R1 half in reset", half_out, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 full after reset", full_out, 1'b0);
    rcnt = 0;
    nrat = ratio(div_code);
  endtask

  task automatic t_off();
    for (int i = 0; i < 5; i++) one_pulse("R6 off code");
  endtask

  task automatic t_ratios();
    for (int c = 1; c <= 6; c++) begin
      set_code(3'(c));
      for (int i = 0; i < 2 * nrat + 2; i++)
        one_pulse(((nrat % 2) == 1) ? "R3 R4 R5 odd ratio" : "R3 R4 R5 even ratio");
    end
  endtask

  task automatic t_pass_latency();
    set_code(3'b000);
    @(negedge clk);
    pulse_in = 1'b1;
    rcnt++;
    @(negedge clk);
    chk("R9 full not yet high after one edge", full_out, 1'b0);
    @(negedge clk);
    chk("R9 R2 full high after two edges", full_out, 1'b1);
    chk("R2 half toggled on first pass pulse", half_out, 1'b1);
    pulse_in = 1'b0;
    @(negedge clk);
    chk("R9 full still high one edge after fall", full_out, 1'b1);
    @(negedge clk);
    chk("R9 R2 full low two edges after fall", full_out, 1'b0);
    for (int i = 0; i < 4; i++) one_pulse("R2 pass-through");
  endtask

  task automatic t_change_midstream();
    set_code(3'b001);
    for (int i = 0; i < 6; i++) one_pulse("R3 ratio 9 prefix");
    chk("R7 full high before change", full_out, 1'b1);
    set_code(3'b100);
    for (int i = 0; i < 7; i++) one_pulse("R7 restart at ratio 6");
  endtask

  task automatic t_pass_hold();
    @(negedge clk);
    pulse_in = 1'b1;
    repeat (3) @(negedge clk);
    div_code = 3'b000;
    @(negedge clk);
    chk("R7 full cleared entering pass-through", full_out, 1'b0);
    repeat (4) @(negedge clk);
    chk("R8 full held low during old pulse", full_out, 1'b0);
    chk("R8 half held low during old pulse", half_out, 1'b0);
    pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    rcnt = 0;
    nrat = 1;
    one_pulse("R8 pass-through resumes");
  endtask

  initial begin
    t_reset();
    t_off();
    t_ratios();
    t_pass_latency();
    t_change_midstream();
    set_code(3'b010);
    for (int i = 0; i < 2; i++) one_pulse("R4 ratio 7 before hold test");
    t_pass_hold();
    set_code(3'b111);
    for (int i = 0; i < 3; i++) one_pulse("R6 off after activity");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule